// File: doc/BRIEF.md
# Display Power-On Reset Sequencer

This block takes a small serial display controller from an unknown state to a known, ready one. On a start pulse it optionally asks the panel for its power-mode status byte and, when the panel reports that it is already showing an image, finishes at once with an "already on" verdict so that no visible flicker is caused. Otherwise it drives the panel's active-low hardware reset pin, if one is wired, sends a parameterless soft-reset command, and waits out the settling time before it reports completion. All waits come from a cycle counter whose limits are computed from the clock frequency and the delay parameters given in microseconds.

The block does not move bits on the wire. It presents one command at a time to a serial link engine through a request/acknowledge handshake: an opcode, a read flag, and a clock divider that keeps read transactions slow. The engine answers with an acknowledge pulse, an error flag and, for reads, one data byte. Outcome flags stay valid until the next accepted start.

States: `ST_IDLE`, `ST_QUERY` (power-mode read outstanding), `ST_HOLD` (reset pin low), `ST_RELEASE` (pin high, recovery wait), `ST_SOFT` (soft-reset command outstanding), `ST_SETTLE` (post-command wait). Transitions: IDLE to QUERY on start in conditional mode; IDLE to HOLD on start with a pin; IDLE to SOFT on start with no pin; QUERY to IDLE on acknowledge with an "on" verdict; QUERY to HOLD or SOFT on any other acknowledge; HOLD to RELEASE and RELEASE to SOFT when the timer expires; SOFT to IDLE on an acknowledge with error; SOFT to SETTLE on a clean acknowledge; SETTLE to IDLE when the timer expires.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, lcd_rst_n is high, cmd_req is low, and busy, done, already_on and error are all low.
- R2: With has_rst_pin high at start and no "on" verdict, lcd_rst_n is driven low for exactly ceil(CLK_HZ*LOW_US/1e6) cycles.
- R3: After lcd_rst_n returns high, cmd_req stays low for exactly ceil(CLK_HZ*REL_US/1e6) cycles, then the soft-reset command is requested with cmd_op = 0x01 and cmd_read = 0; cmd_req is never high while lcd_rst_n is low.
- R4: After a clean soft-reset acknowledge, done rises POST cycles later, where POST is ceil(CLK_HZ*POST_PIN_US/1e6) if the pin was present and ceil(CLK_HZ*POST_NOPIN_US/1e6) if not; without a pin, lcd_rst_n never goes low and the soft-reset request appears in the first busy cycle.
- R5: With cond_mode high at start, the first command is the power-mode read, cmd_op = 0x0A with cmd_read = 1.
- R6: The panel is judged on when the read is acknowledged without error and (cmd_rdata AND 0x7C) equals 0x1C (bits 2, 3, 4 set; bits 5 and 6 clear; bits 0, 1, 7 ignored); then done and already_on go high, no reset pulse and no further command follow.
- R7: Any other read outcome (a bit among 2..4 clear, partial-mode bit 5 or idle-mode bit 6 set, or cmd_err on the read) continues into the full reset sequence with already_on low.
- R8: cmd_err on the soft-reset acknowledge ends the sequence with error high and done low.
- R9: cmd_div equals ceil(CLK_HZ / min(RD_CAP_HZ, LINK_MAX_HZ/2)) while a read is requested and ceil(CLK_HZ / LINK_MAX_HZ) while a write is requested.
- R10: A start while busy is ignored; has_rst_pin and cond_mode take effect only as sampled with an accepted start.
- R11: done, already_on and error hold their values in idle until the next accepted start, which clears them.
- R12: Once raised, cmd_req and cmd_op hold steady until cmd_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only in idle |
| cond_mode | input | 1 | Query the power-mode byte before resetting |
| has_rst_pin | input | 1 | A hardware reset pin is wired to the panel |
| lcd_rst_n | output | 1 | Active-low panel reset pin |
| cmd_req | output | 1 | Command request to the link engine |
| cmd_op | output | 8 | Command opcode |
| cmd_read | output | 1 | Request is a one-byte read |
| cmd_div | output | DIV_W | Link clock divider for this request |
| cmd_ack | input | 1 | Link engine finished the request |
| cmd_err | input | 1 | Request failed, valid with cmd_ack |
| cmd_rdata | input | 8 | Byte read, valid with cmd_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| already_on | output | 1 | Panel was found on; no reset applied |
| error | output | 1 | Soft-reset command failed |

## Verification
A wrong state in this controller shows at the ports almost at once: a wrong branch after the status read appears as a reset pulse or a command where none belongs, within one cycle of the acknowledge. A timer loaded with the wrong limit, or a wrong pin setting latched at start, is visible only as a pulse width, recovery gap or settle time off by some cycles, so the bench measures each interval exactly. Flag errors show as done and error overlapping, or as stale flags after a new start.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUERY,
        ST_HOLD,
        ST_RELEASE,
        ST_SOFT,
        ST_SETTLE
    } seq_state_e;

    localparam logic [7:0] OP_NONE       = 8'h00;
    localparam logic [7:0] OP_SOFT_RESET = 8'h01;
    localparam logic [7:0] OP_GET_POWER  = 8'h0A;

    // bits that matter in the power-mode byte, and the pattern meaning "showing"
    localparam logic [7:0] PWR_CARE_MASK  = 8'h7C;
    localparam logic [7:0] PWR_ON_PATTERN = 8'h1C;

    function automatic longint ceil_div(longint num, longint den);
        longint q;
        if (den <= 0) begin
            q = 1;
        end else begin
            q = (num + den - 1) / den;
        end
        if (q < 1) begin
            q = 1;
        end
        return q;
    endfunction

    function automatic longint us_to_cycles(longint clk_hz, longint us);
        return ceil_div(clk_hz * us, 64'd1000000);
    endfunction

    function automatic longint max2(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/dseq_status_eval.sv
module dseq_status_eval
    import dseq_pkg::*;
#(
    parameter logic [7:0] CARE_MASK  = PWR_CARE_MASK,
    parameter logic [7:0] ON_PATTERN = PWR_ON_PATTERN
) (
    input  logic [7:0] status_byte,
    input  logic       read_failed,
    output logic       panel_on
);

    logic [7:0] relevant;

    always_comb begin
        relevant = status_byte & CARE_MASK;
        panel_on = !read_failed && (relevant == ON_PATTERN);
    end

endmodule

// File: rtl/dseq_rate_sel.sv
module dseq_rate_sel
    import dseq_pkg::*;
#(
    parameter longint CLK_HZ      = 125_000_000,
    parameter longint LINK_MAX_HZ = 20_000_000,
    parameter longint RD_CAP_HZ   = 2_000_000,
    parameter int     DIV_W       = 16
) (
    input  logic             is_read,
    output logic [DIV_W-1:0] div
);

    localparam longint HALF_LINK = LINK_MAX_HZ / 2;
    localparam longint RD_HZ     = (HALF_LINK < RD_CAP_HZ) ? HALF_LINK : RD_CAP_HZ;
    localparam longint RD_DIV    = ceil_div(CLK_HZ, RD_HZ);
    localparam longint WR_DIV    = ceil_div(CLK_HZ, LINK_MAX_HZ);

    localparam logic [DIV_W-1:0] RD_DIV_V = DIV_W'(RD_DIV);
    localparam logic [DIV_W-1:0] WR_DIV_V = DIV_W'(WR_DIV);

    assign div = is_read ? RD_DIV_V : WR_DIV_V;

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
    import dseq_pkg::*;
#(
    parameter longint CLK_HZ        = 125_000_000,
    parameter longint LINK_MAX_HZ   = 20_000_000,
    parameter longint RD_CAP_HZ     = 2_000_000,
    parameter longint LOW_US        = 20,
    parameter longint REL_US        = 120_000,
    parameter longint POST_PIN_US   = 5_000,
    parameter longint POST_NOPIN_US = 120_000,
    parameter int     DIV_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cond_mode,
    input  logic             has_rst_pin,
    output logic             lcd_rst_n,
    output logic             cmd_req,
    output logic [7:0]       cmd_op,
    output logic             cmd_read,
    output logic [DIV_W-1:0] cmd_div,
    input  logic             cmd_ack,
    input  logic             cmd_err,
    input  logic [7:0]       cmd_rdata,
    output logic             busy,
    output logic             done,
    output logic             already_on,
    output logic             error
);

    localparam longint LOW_CYC   = us_to_cycles(CLK_HZ, LOW_US);
    localparam longint REL_CYC   = us_to_cycles(CLK_HZ, REL_US);
    localparam longint PPIN_CYC  = us_to_cycles(CLK_HZ, POST_PIN_US);
    localparam longint PNONE_CYC = us_to_cycles(CLK_HZ, POST_NOPIN_US);
    localparam longint MAX_CYC   = max2(max2(LOW_CYC, REL_CYC), max2(PPIN_CYC, PNONE_CYC));
    localparam int     CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LOAD_LOW   = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_REL   = CNT_W'(REL_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_PPIN  = CNT_W'(PPIN_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_PNONE = CNT_W'(PNONE_CYC - 1);

    seq_state_e       state, state_nx;
    logic             pin_cfg;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             panel_on;
    logic             accept_start;

    assign accept_start = (state == ST_IDLE) && start;

    dseq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dseq_status_eval u_eval (
        .status_byte (cmd_rdata),
        .read_failed (cmd_err),
        .panel_on    (panel_on)
    );

    dseq_rate_sel #(
        .CLK_HZ      (CLK_HZ),
        .LINK_MAX_HZ (LINK_MAX_HZ),
        .RD_CAP_HZ   (RD_CAP_HZ),
        .DIV_W       (DIV_W)
    ) u_rate (
        .is_read (cmd_read),
        .div     (cmd_div)
    );

    // next state and timer loading
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cond_mode) begin
                        state_nx = ST_QUERY;
                    end else if (has_rst_pin) begin
                        state_nx = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = LOAD_LOW;
                    end else begin
                        state_nx = ST_SOFT;
                    end
                end
            end
            ST_QUERY: begin
                if (cmd_ack) begin
                    if (panel_on) begin
                        state_nx = ST_IDLE;
                    end else if (pin_cfg) begin
                        state_nx = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = LOAD_LOW;
                    end else begin
                        state_nx = ST_SOFT;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    state_nx = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = LOAD_REL;
                end
            end
            ST_RELEASE: begin
                if (tmr_expired) begin
                    state_nx = ST_SOFT;
                end
            end
            ST_SOFT: begin
                if (cmd_ack) begin
                    if (cmd_err) begin
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = pin_cfg ? LOAD_PPIN : LOAD_PNONE;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // state register, latched configuration and outcome flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pin_cfg    <= 1'b0;
            done       <= 1'b0;
            already_on <= 1'b0;
            error      <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept_start) begin
                pin_cfg    <= has_rst_pin;
                done       <= 1'b0;
                already_on <= 1'b0;
                error      <= 1'b0;
            end
            if ((state == ST_QUERY) && cmd_ack && panel_on) begin
                done       <= 1'b1;
                already_on <= 1'b1;
            end
            if ((state == ST_SOFT) && cmd_ack && cmd_err) begin
                error <= 1'b1;
            end
            if ((state == ST_SETTLE) && tmr_expired) begin
                done <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        lcd_rst_n = 1'b1;
        cmd_req   = 1'b0;
        cmd_op    = OP_NONE;
        cmd_read  = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_QUERY: begin
                cmd_req  = 1'b1;
                cmd_op   = OP_GET_POWER;
                cmd_read = 1'b1;
            end
            ST_HOLD: begin
                lcd_rst_n = 1'b0;
            end
            ST_RELEASE: begin
                lcd_rst_n = 1'b1;
            end
            ST_SOFT: begin
                cmd_req = 1'b1;
                cmd_op  = OP_SOFT_RESET;
            end
            ST_SETTLE: begin
                lcd_rst_n = 1'b1;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk
    import dseq_pkg::*;
#(
    parameter longint CLK_HZ      = 125_000_000,
    parameter longint LINK_MAX_HZ = 20_000_000,
    parameter longint RD_CAP_HZ   = 2_000_000,
    parameter longint LOW_US      = 20,
    parameter int     DIV_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lcd_rst_n,
    input logic             cmd_req,
    input logic [7:0]       cmd_op,
    input logic             cmd_read,
    input logic [DIV_W-1:0] cmd_div,
    input logic             cmd_ack,
    input logic             busy,
    input logic             done,
    input logic             already_on,
    input logic             error
);

    localparam longint LOW_CYC = us_to_cycles(CLK_HZ, LOW_US);
    localparam longint RD_HZ   = ((LINK_MAX_HZ / 2) < RD_CAP_HZ) ? (LINK_MAX_HZ / 2) : RD_CAP_HZ;
    localparam logic [DIV_W-1:0] RD_DIV_C = DIV_W'(ceil_div(CLK_HZ, RD_HZ));
    localparam logic [31:0]      LOW_C    = 32'(LOW_CYC);

    logic [31:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!lcd_rst_n) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lcd_rst_n && !cmd_req));

    assert_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_rst_n) |-> (low_run == LOW_C));

    assert_no_cmd_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> !cmd_req);

    assert_on_means_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        already_on |-> done);

    assert_err_excl_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(error && done));

    assert_read_slow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_read) |-> (cmd_div == RD_DIV_C));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op)));

endmodule

bind disp_pwr_seq disp_pwr_seq_chk #(
    .CLK_HZ      (CLK_HZ),
    .LINK_MAX_HZ (LINK_MAX_HZ),
    .RD_CAP_HZ   (RD_CAP_HZ),
    .LOW_US      (LOW_US),
    .DIV_W       (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcd_rst_n  (lcd_rst_n),
    .cmd_req    (cmd_req),
    .cmd_op     (cmd_op),
    .cmd_read   (cmd_read),
    .cmd_div    (cmd_div),
    .cmd_ack    (cmd_ack),
    .busy       (busy),
    .done       (done),
    .already_on (already_on),
    .error      (error)
);

// File: tb/tb_disp_pwr_seq.sv
module tb_disp_pwr_seq;

    localparam longint CLK_HZ   = 8_000_000;
    localparam longint LINK_HZ  = 3_000_000;
    localparam longint CAP_HZ   = 2_000_000;
    localparam longint LOW_US   = 20;
    localparam longint REL_US   = 200;
    localparam longint PPIN_US  = 50;
    localparam longint PNONE_US = 300;
    localparam int     DIV_W    = 16;

    // expectations derived from the requirement formulas
    localparam int E_LOW   = int'((CLK_HZ * LOW_US + 999_999) / 1_000_000);
    localparam int E_REL   = int'((CLK_HZ * REL_US + 999_999) / 1_000_000);
    localparam int E_PPIN  = int'((CLK_HZ * PPIN_US + 999_999) / 1_000_000);
    localparam int E_PNONE = int'((CLK_HZ * PNONE_US + 999_999) / 1_000_000);
    localparam longint E_RDHZ = ((LINK_HZ / 2) < CAP_HZ) ? (LINK_HZ / 2) : CAP_HZ;
    localparam int E_RDDIV = int'((CLK_HZ + E_RDHZ - 1) / E_RDHZ);
    localparam int E_WRDIV = int'((CLK_HZ + LINK_HZ - 1) / LINK_HZ);
    localparam int WDOG    = 150_000;

    // {pin, read_err, status[7:0], expect_on}
    localparam logic [10:0] VEC [0:7] = '{
        {1'b1, 1'b0, 8'h1C, 1'b1},
        {1'b0, 1'b0, 8'h9F, 1'b1},
        {1'b1, 1'b0, 8'h3C, 1'b0},
        {1'b0, 1'b0, 8'h5C, 1'b0},
        {1'b1, 1'b0, 8'h08, 1'b0},
        {1'b0, 1'b1, 8'h1C, 1'b0},
        {1'b1, 1'b0, 8'h1D, 1'b1},
        {1'b0, 1'b0, 8'hFF, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cond_mode = 1'b0;
    logic has_rst_pin = 1'b0;
    logic cmd_ack = 1'b0;
    logic cmd_err = 1'b0;
    logic [7:0] cmd_rdata = 8'h00;
    logic lcd_rst_n, cmd_req, cmd_read, busy, done, already_on, error;
    logic [7:0] cmd_op;
    logic [DIV_W-1:0] cmd_div;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t_busy, t_fall, t_rise, t_sack, t_done;
    int n_cmds;
    logic [7:0] op0;
    logic rd0;
    int div_rd, div_wr;
    bit pulse_seen;
    bit prev_busy = 1'b0;
    bit prev_done = 1'b0;
    bit prev_rst = 1'b1;
    bit rsp_rd_err = 1'b0;
    bit rsp_sr_err = 1'b0;
    logic [7:0] rsp_status = 8'h00;

    always #4 clk = ~clk;

    disp_pwr_seq #(
        .CLK_HZ        (CLK_HZ),
        .LINK_MAX_HZ   (LINK_HZ),
        .RD_CAP_HZ     (CAP_HZ),
        .LOW_US        (LOW_US),
        .REL_US        (REL_US),
        .POST_PIN_US   (PPIN_US),
        .POST_NOPIN_US (PNONE_US),
        .DIV_W         (DIV_W)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cond_mode   (cond_mode),
        .has_rst_pin (has_rst_pin),
        .lcd_rst_n   (lcd_rst_n),
        .cmd_req     (cmd_req),
        .cmd_op      (cmd_op),
        .cmd_read    (cmd_read),
        .cmd_div     (cmd_div),
        .cmd_ack     (cmd_ack),
        .cmd_err     (cmd_err),
        .cmd_rdata   (cmd_rdata),
        .busy        (busy),
        .done        (done),
        .already_on  (already_on),
        .error       (error)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor and link-engine model, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (busy === 1'b1 && !prev_busy) t_busy = cyc;
        if (lcd_rst_n === 1'b0 && prev_rst) begin
            t_fall = cyc;
            pulse_seen = 1'b1;
        end
        if (lcd_rst_n === 1'b1 && !prev_rst) t_rise = cyc;
        if (done === 1'b1 && !prev_done) t_done = cyc;
        prev_busy = (busy === 1'b1);
        prev_done = (done === 1'b1);
        prev_rst  = (lcd_rst_n !== 1'b0);
        if (cmd_ack) begin
            cmd_ack = 1'b0;
            cmd_err = 1'b0;
        end else if (cmd_req === 1'b1) begin
            if (n_cmds == 0) begin
                op0 = cmd_op;
                rd0 = cmd_read;
            end
            if (cmd_read) div_rd = int'(cmd_div);
            else div_wr = int'(cmd_div);
            if (cmd_op == 8'h01) begin
                t_sack  = cyc;
                cmd_err = rsp_sr_err;
            end else begin
                cmd_err   = rsp_rd_err;
                cmd_rdata = rsp_status;
            end
            n_cmds++;
            cmd_ack = 1'b1;
        end
        if (cyc > WDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            finish_run();
        end
    end

    task automatic clear_log();
        n_cmds = 0;
        pulse_seen = 1'b0;
        t_busy = -1; t_fall = -1; t_rise = -1; t_sack = -1; t_done = -1;
        op0 = 8'hEE; rd0 = 1'b0; div_rd = -1; div_wr = -1;
    endtask

    task automatic kick(bit c, bit p);
        clear_log();
        @(negedge clk);
        start = 1'b1;
        cond_mode = c;
        has_rst_pin = p;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        clear_log();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet after reset
        chk("R1 lcd_rst_n", lcd_rst_n, 1);
        chk("R1 cmd_req", cmd_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 flags", {done, already_on, error}, 0);

        // conditional-mode table: R5 R6 R7 R9
        for (int i = 0; i < 8; i++) begin
            rsp_status = VEC[i][8:1];
            rsp_rd_err = VEC[i][9];
            kick(1'b1, VEC[i][10]);
            wait_idle();
            chk("R5 first op", op0, 8'h0A);
            chk("R5 first is read", rd0, 1);
            chk("R9 read div", div_rd, E_RDDIV);
            chk("R6 R7 already_on", already_on, VEC[i][0]);
            chk("R6 R7 done", done, 1);
            chk("R6 R7 command count", n_cmds, VEC[i][0] ? 1 : 2);
            chk("R6 R7 pin pulse", pulse_seen, (!VEC[i][0]) && VEC[i][10]);
        end
        rsp_rd_err = 1'b0;

        // R2 R3 R4 R9: pin present, unconditional
        kick(1'b0, 1'b1);
        wait_idle();
        chk("R2 low width", t_rise - t_fall, E_LOW);
        chk("R3 recovery gap", t_sack - t_rise, E_REL);
        chk("R3 op", op0, 8'h01);
        chk("R3 write", rd0, 0);
        chk("R9 write div", div_wr, E_WRDIV);
        chk("R4 settle with pin", t_done - t_sack, E_PPIN + 1);
        chk("R4 done", done, 1);
        chk("R4 single command", n_cmds, 1);

        // R4: no pin
        kick(1'b0, 1'b0);
        wait_idle();
        chk("R4 no pulse", pulse_seen, 0);
        chk("R4 immediate request", t_sack - t_busy, 0);
        chk("R4 settle no pin", t_done - t_sack, E_PNONE + 1);

        // R8: soft-reset failure, R11 flag hold
        rsp_sr_err = 1'b1;
        kick(1'b0, 1'b1);
        wait_idle();
        rsp_sr_err = 1'b0;
        chk("R8 error", error, 1);
        chk("R8 no done", done, 0);
        repeat (10) @(negedge clk);
        chk("R11 error held", error, 1);
        kick(1'b0, 1'b0);
        chk("R11 cleared on start", error, 0);
        wait_idle();
        chk("R11 done after clear", done, 1);

        // R10: start while busy ignored, pin setting latched
        kick(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        start = 1'b1;
        cond_mode = 1'b1;
        has_rst_pin = 1'b0;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk("R10 low width kept", t_rise - t_fall, E_LOW);
        chk("R10 no extra command", n_cmds, 1);
        chk("R10 first op", op0, 8'h01);
        chk("R10 latched pin settle", t_done - t_sack, E_PPIN + 1);
        chk("R12 done", done, 1);

        finish_run();
    end

endmodule